// File: doc/BRIEF.md
# Character Row Word Buffer

This block is a small on-chip store that holds one text row for a character-mode video generator. The row has 40 cells. Each cell is a 16-bit word: an 8-bit attribute in the low byte lane and an 8-bit character pointer in the high byte lane. Memory returns data over an 8-bit bus, so a row is loaded over two fetch lines. On one line, each arriving byte goes into the attribute lane of its column. On the other line, each byte goes into the pointer lane. Both fills use the same slot timing and differ only in which lane is written.

The buffer runs at twice the character rate, which gives each character period two access slots. The first slot is a read and the second is a write. In the read slot, the buffer presents the word for the column after the one whose bitmap is being fetched, so the pixel pipeline always has its next character one period in advance. In the write slot, the byte from memory may be stored into the current column. Reads leave the stored data intact, so the same row can be replayed on every raster line of the text row.

Top module: `charrow_buf`

## Requirements
- R1: The buffer holds 40 words. Each word has two byte lanes: lane 0 is the attribute, shown on `rd_attr`, and lane 1 is the character pointer, shown on `rd_ptr`.
- R2: After reset, `rd_valid` is 0. It stays 0 through any number of `char_strobe` pulses until the first `line_start`.
- R3: A `line_start` clears the column counter to 0. On the next clock edge, `rd_valid` becomes 1 and the outputs show the word of column 0. If `line_start` and `char_strobe` are high in the same cycle, `line_start` wins and the counter does not advance.
- R4: A `char_strobe` taken while the counter holds column c, with c < 39, advances the counter to c+1. On that same edge, the outputs show the word of column c+1 with `rd_valid` = 1.
- R5: The counter saturates at 39. A `char_strobe` taken at column 39 drives `rd_valid` to 0 and leaves `rd_ptr` and `rd_attr` unchanged.
- R6: The clock cycle after a `char_strobe` is the write slot, and its target is column c, the counter value when the strobe was taken. If `fill_attr` is high in that slot, `mem_data` is written into lane 0 of column c. If `fill_ptr` is high, `mem_data` is written into lane 1 of column c.
- R7: A write to one lane leaves the other lane of the same word unchanged.
- R8: If neither `fill_attr` nor `fill_ptr` is high in the write slot, no cell changes, whatever `mem_data` carries.
- R9: Reads do not disturb the stored data. A row can be read on any number of lines with identical results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the character rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Start-of-raster-line pulse |
| char_strobe | input | 1 | One pulse per character period; marks the read slot |
| fill_attr | input | 1 | Write slot stores into the attribute lane |
| fill_ptr | input | 1 | Write slot stores into the pointer lane |
| mem_data | input | 8 | Byte returned by memory for the write slot |
| rd_ptr | output | 8 | Character pointer of the word being replayed |
| rd_attr | output | 8 | Attribute of the word being replayed |
| rd_valid | output | 1 | Replayed word is a real column of the row |

## Verification
The read outputs are registered, so they change on the same clock edge that samples `line_start` or `char_strobe`. The bench drives its inputs on falling edges and checks the outputs at the next falling edge, which is half a period after the read edge. A write commits on the edge that closes the write slot. Because each read is of column c+1 while the write goes to column c, a written byte first becomes visible when the following line reads that column. The bench therefore updates its model only after each write slot and compares every read against the contents as they stood before the current line. Hold behaviour at saturation is checked by capturing the outputs just before the strobe and comparing them half a period after the edge.

// File: rtl/charrow_pkg.sv
package charrow_pkg;
   localparam int LANES = 2;
   typedef enum int unsigned {
      LANE_ATTR = 0,
      LANE_PTR  = 1
   } lane_e;
endpackage

// File: rtl/charrow_colctr.sv
module charrow_colctr #(
   parameter int WORDS  = 40,
   parameter int ADDR_W = $clog2(WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   output logic [ADDR_W-1:0] col,
   output logic              at_last
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);

   if (WORDS < 2) begin : g_bad_words
      $error("charrow_colctr: WORDS must be at least 2");
   end

   assign at_last = (col == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)           col <= '0;
      else if (clear)       col <= '0;
      else if (step && !at_last) col <= col + 1'b1;
   end

   // R5
   col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col <= LAST);

   // R4
   col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && !at_last) |=> (col == $past(col) + 1'b1));

   // R3
   col_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (col == '0));
endmodule

// File: rtl/charrow_store.sv
module charrow_store
   import charrow_pkg::*;
#(
   parameter int WORDS  = 40,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = $clog2(WORDS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic [LANES-1:0]        wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [BYTE_W-1:0]       wr_byte,
   output logic [LANES*BYTE_W-1:0] rd_word
);
   if (BYTE_W < 1) begin : g_bad_byte
      $error("charrow_store: BYTE_W must be positive");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [BYTE_W-1:0] cells [WORDS];
      logic [BYTE_W-1:0] q;

      always_ff @(posedge clk) begin
         if (wr_en[l]) cells[wr_addr] <= wr_byte;
      end

      always_ff @(posedge clk) begin
         if (rd_en) q <= cells[rd_addr];
      end

      assign rd_word[l*BYTE_W +: BYTE_W] = q;
   end

   // R7
   one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));

   // R1
   rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_addr < ADDR_W'(WORDS)));

   // R6
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_en) |-> (wr_addr < ADDR_W'(WORDS)));
endmodule

// File: rtl/charrow_buf.sv
module charrow_buf
   import charrow_pkg::*;
#(
   parameter int WORDS  = 40,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              char_strobe,
   input  logic              fill_attr,
   input  logic              fill_ptr,
   input  logic [BYTE_W-1:0] mem_data,
   output logic [BYTE_W-1:0] rd_ptr,
   output logic [BYTE_W-1:0] rd_attr,
   output logic              rd_valid
);
   localparam int ADDR_W = $clog2(WORDS + 1);

   logic [ADDR_W-1:0]       col;
   logic                    at_last;
   logic                    started;
   logic                    wr_pend;
   logic [ADDR_W-1:0]       wr_col;
   logic                    rd_en;
   logic [ADDR_W-1:0]       rd_addr;
   logic [LANES-1:0]        wr_en;
   logic [LANES*BYTE_W-1:0] rd_word;
   logic                    strobe_take;

   assign strobe_take = char_strobe && !line_start;

   charrow_colctr #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_col (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (line_start),
      .step    (char_strobe),
      .col     (col),
      .at_last (at_last)
   );

   // read slot: line start fetches column 0, a strobe fetches one column ahead
   always_comb begin
      rd_en   = line_start || (char_strobe && !at_last);
      rd_addr = line_start ? '0 : col + 1'b1;
   end

   // write slot: the cycle that follows an accepted strobe
   always_comb begin
      wr_en = '0;
      wr_en[LANE_ATTR] = wr_pend && fill_attr;
      wr_en[LANE_PTR]  = wr_pend && fill_ptr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started  <= 1'b0;
         rd_valid <= 1'b0;
         wr_pend  <= 1'b0;
         wr_col   <= '0;
      end else begin
         wr_pend <= strobe_take;
         if (strobe_take) wr_col <= col;
         if (line_start) begin
            started  <= 1'b1;
            rd_valid <= 1'b1;
         end else if (char_strobe) begin
            rd_valid <= started && !at_last;
         end
      end
   end

   charrow_store #(.WORDS(WORDS), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .wr_en   (wr_en),
      .wr_addr (wr_col),
      .wr_byte (mem_data),
      .rd_word (rd_word)
   );

   assign rd_attr = rd_word[LANE_ATTR*BYTE_W +: BYTE_W];
   assign rd_ptr  = rd_word[LANE_PTR*BYTE_W +: BYTE_W];

   // R2
   quiet_before_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> !rd_valid);

   // R3
   line_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> rd_valid);

   // R5
   hold_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_take && at_last) |=> (!rd_valid && $stable(rd_ptr) && $stable(rd_attr)));

   // R8
   no_fill_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fill_attr && !fill_ptr) |-> (wr_en == '0));

   // R6
   fill_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_attr && fill_ptr));
endmodule

// File: tb/sim_charrow_buf.sv
module sim_charrow_buf;
   localparam int CLK_PERIOD = 10;
   localparam int NCOL = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_start = 1'b0;
   logic       char_strobe = 1'b0;
   logic       fill_attr = 1'b0;
   logic       fill_ptr = 1'b0;
   logic [7:0] mem_data = 8'h00;
   logic [7:0] rd_ptr, rd_attr;
   logic       rd_valid;

   int checks = 0;
   int errors = 0;

   logic [7:0] m_attr [NCOL];
   logic [7:0] m_ptr  [NCOL];
   bit         k_attr [NCOL];
   bit         k_ptr  [NCOL];

   // {mode[1:0], base[7:0], step[7:0]}; mode 0 = display only, 1 = attr fill, 2 = ptr fill
   localparam logic [17:0] LINES [8] = '{
      {2'd1, 8'h10, 8'h03},
      {2'd2, 8'hA0, 8'h05},
      {2'd0, 8'hFF, 8'h11},
      {2'd1, 8'h55, 8'h07},
      {2'd0, 8'h3C, 8'h01},
      {2'd2, 8'h01, 8'h02},
      {2'd0, 8'h00, 8'h01},
      {2'd0, 8'hC3, 8'h09}
   };

   always #(CLK_PERIOD/2) clk = ~clk;

   charrow_buf u0 (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .char_strobe(char_strobe),
      .fill_attr(fill_attr), .fill_ptr(fill_ptr), .mem_data(mem_data),
      .rd_ptr(rd_ptr), .rd_attr(rd_attr), .rd_valid(rd_valid)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_word(input int c, input string req);
      if (k_attr[c]) chk(rd_attr == m_attr[c], req, rd_attr, m_attr[c]);
      if (k_ptr[c])  chk(rd_ptr == m_ptr[c], req, rd_ptr, m_ptr[c]);
   endtask

   // one character period; caller sits at a falling edge, bench counter is c
   task automatic do_char(input int c, input bit fa, input bit fp, input logic [7:0] d);
      logic [7:0] p0, a0;
      p0 = rd_ptr; a0 = rd_attr;
      char_strobe = 1'b1;
      @(negedge clk);
      char_strobe = 1'b0;
      if (c < NCOL-1) begin
         chk(rd_valid == 1'b1, "R4 valid", rd_valid, 1);
         chk_word(c+1, "R1/R4/R6/R7/R8/R9 word");
      end else begin
         chk(rd_valid == 1'b0, "R5 valid", rd_valid, 0);
         chk(rd_ptr == p0, "R5 ptr hold", rd_ptr, p0);
         chk(rd_attr == a0, "R5 attr hold", rd_attr, a0);
      end
      fill_attr = fa; fill_ptr = fp; mem_data = d;
      @(negedge clk);
      fill_attr = 1'b0; fill_ptr = 1'b0;
      if (fa) begin m_attr[c] = d; k_attr[c] = 1'b1; end
      if (fp) begin m_ptr[c] = d; k_ptr[c] = 1'b1; end
   endtask

   task automatic do_line_start();
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      chk(rd_valid == 1'b1, "R3 valid", rd_valid, 1);
      chk_word(0, "R3 word");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NCOL; i++) begin k_attr[i] = 0; k_ptr[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_valid == 1'b0, "R2 reset", rd_valid, 0);
      // strobes before any line start keep rd_valid low (no fills)
      for (int i = 0; i < 3; i++) begin
         char_strobe = 1'b1;
         @(negedge clk);
         char_strobe = 1'b0;
         chk(rd_valid == 1'b0, "R2 pre-line", rd_valid, 0);
         mem_data = 8'hEE;
         @(negedge clk);
      end

      // table walk: each entry is one raster line of 40 character periods
      for (int ln = 0; ln < 8; ln++) begin
         logic [1:0] mode;
         logic [7:0] base, stp;
         {mode, base, stp} = LINES[ln];
         do_line_start();
         for (int c = 0; c < NCOL; c++)
            do_char(c, mode == 2'd1, mode == 2'd2, 8'(base + stp * 8'(c)));
         @(negedge clk);
      end

      // R5: strobes beyond the last column keep the word and stay invalid
      for (int i = 0; i < 3; i++) do_char(NCOL-1, 1'b0, 1'b0, 8'h99);

      // R3: line start in mid-row returns to column 0
      do_line_start();
      for (int c = 0; c < 10; c++) do_char(c, 1'b0, 1'b0, 8'h77);
      do_line_start();

      // R3: line start together with a strobe does not advance the counter
      line_start = 1'b1; char_strobe = 1'b1;
      @(negedge clk);
      line_start = 1'b0; char_strobe = 1'b0;
      chk(rd_valid == 1'b1, "R3 collide valid", rd_valid, 1);
      chk_word(0, "R3 collide word");
      @(negedge clk);
      do_char(0, 1'b0, 1'b0, 8'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule